// File: doc/BRIEF.md
# Destination Address Hash and Exact-Match Filter

This block decides whether a received frame is addressed to this station. As the six destination-address bytes arrive one per accepted cycle, it folds each byte into a running CRC-32. It also collects the bytes into a 48-bit word. When the sixth byte is taken, two tests run in the same cycle. The top six bits of the finished CRC select one bit of a 64-bit hash table, and the collected address is compared with a programmed station address. One cycle later the block pulses a result strobe. Alongside it come the combined verdict, the two partial verdicts and the hash index.

Software programs the station address and the two 32-bit halves of the hash table through a small word-select register port. Reads return one cycle after the select is presented. A start-of-frame pulse re-arms the address collector. Bytes arriving while the collector is not armed are discarded. This covers bytes after reset before the first start pulse, and bytes beyond the sixth.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset the result strobe, verdicts and index are 0, and the station address and both table words are 0. A read of select 1 then returns 0x00008808.
- R2: The CRC starts at 0xFFFFFFFF. It takes each byte least significant bit first. At every bit it shifts right by one and, when the incoming bit differs from the CRC's bit 0, XORs in 0xEDB88320. Exactly six bytes are folded.
- R3: `res_index` equals the final CRC shifted right by 26, i.e. its bits 31 to 26.
- R4: `res_hash` is table bit (index - 32) of the word at select 2 for an index of 32 to 63. For an index of 0 to 31 it is table bit index of the word at select 3.
- R5: Select 0 holds address bytes 0 to 3, with byte 0 (the first received) in bits 31:24. Select 1 bits 31:24 hold byte 4 and bits 23:16 hold byte 5. `res_exact` is 1 exactly when all six received bytes equal the stored ones.
- R6: Bits 15:0 of select 1 always read 0x8808. Write data on those bits has no effect.
- R7: `res_hit` is 1 when `res_exact` or `res_hash` is 1, and 0 otherwise.
- R8: `res_valid` is a one-cycle pulse on the cycle after the sixth byte is accepted. The verdicts and index change only with that pulse and hold until the next one.
- R9: `rx_sof` restarts collection and the CRC. A byte presented together with `rx_sof` is byte 0. Bytes with no preceding start pulse since reset, and bytes after the sixth, are ignored.
- R10: `cfg_rd_data` returns, one cycle after `cfg_rd_sel` is presented, the register it selects. Written values read back unchanged, except for the fixed bits of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Write word select: 0/1 station address, 2 table upper, 3 table lower |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_sel | input | 2 | Read word select, same coding |
| cfg_rd_data | output | 32 | Registered read data |
| rx_sof | input | 1 | Start-of-frame pulse, re-arms the collector |
| rx_byte_valid | input | 1 | Address byte present |
| rx_byte | input | 8 | Address byte |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Frame accepted (exact or hash) |
| res_exact | output | 1 | Exact station-address match |
| res_hash | output | 1 | Indexed hash-table bit |
| res_index | output | 6 | Hash index from the CRC |

## Verification
The assertions watch on every cycle that the strobe follows the sixth accepted byte by exactly one cycle and never lasts two cycles. They also check that the verdicts move only with the strobe, that an accept always has a cause, and that the fixed field reads back as 0x8808. The CRC value, the split of the index across the two table words, and the byte order of the exact compare can only be shown by the bench. It compares each result against an independently computed CRC over random and directed addresses. The restart, the extra-byte and the unarmed cases are also shown only by the bench.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam logic [31:0] HF_CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] HF_CRC_INIT = 32'hFFFFFFFF;
  localparam logic [15:0] HF_TYPE_TAG = 16'h8808;
  // word-select codes of the register port
  localparam int HF_SEL_STN_HI   = 0;
  localparam int HF_SEL_STN_LO   = 1;
  localparam int HF_SEL_TBL_BASE = 2;  // highest table word first
endpackage

// File: rtl/hf_crc_byte.sv
module hf_crc_byte #(
  parameter int CRC_W  = 32,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = hf_pkg::HF_CRC_POLY
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] acc;

  // reflected shift register, least significant data bit first
  always_comb begin
    acc = crc_in;
    for (int i = 0; i < DATA_W; i++) begin
      if (acc[0] ^ data_in[i]) acc = (acc >> 1) ^ POLY;
      else                     acc = acc >> 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/hf_regs.sv
module hf_regs #(
  parameter int REG_W = 32,
  parameter int N_TBL = 2,
  parameter int SEL_W = 2,
  parameter int TAG_W = 16,
  parameter logic [TAG_W-1:0] TAG = hf_pkg::HF_TYPE_TAG
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic [REG_W-1:0]             wr_data,
  input  logic [SEL_W-1:0]             rd_sel,
  output logic [REG_W-1:0]             rd_data,
  output logic [REG_W-1:0]             stn_hi,
  output logic [REG_W-TAG_W-1:0]       stn_lo,
  output logic [N_TBL-1:0][REG_W-1:0]  tbl
);
  import hf_pkg::*;

  localparam int LO_W = REG_W - TAG_W;

  logic [REG_W-1:0] stn_hi_q;
  logic [LO_W-1:0]  stn_lo_q;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      stn_hi_q <= '0;
      stn_lo_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(HF_SEL_STN_HI)) stn_hi_q <= wr_data;
      if (wr_sel == SEL_W'(HF_SEL_STN_LO)) stn_lo_q <= wr_data[REG_W-1:TAG_W];
    end
  end

  assign stn_hi = stn_hi_q;
  assign stn_lo = stn_lo_q;

  generate
    for (genvar w = 0; w < N_TBL; w++) begin : g_tbl
      localparam int CODE = HF_SEL_TBL_BASE + (N_TBL - 1 - w);
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)                                   word_q <= '0;
        else if (wr_en && wr_sel == SEL_W'(CODE))  word_q <= wr_data;
      end
      assign tbl[w] = word_q;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (rd_sel == SEL_W'(HF_SEL_STN_HI)) rd_mux = stn_hi_q;
    if (rd_sel == SEL_W'(HF_SEL_STN_LO)) rd_mux = {stn_lo_q, TAG};
    for (int w = 0; w < N_TBL; w++) begin
      if (rd_sel == SEL_W'(HF_SEL_TBL_BASE + N_TBL - 1 - w)) rd_mux = tbl[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/hf_seq.sv
module hf_seq #(
  parameter int ADDR_BYTES = 6,
  parameter int CRC_W      = 32,
  parameter logic [CRC_W-1:0] POLY = hf_pkg::HF_CRC_POLY,
  parameter logic [CRC_W-1:0] INIT = hf_pkg::HF_CRC_INIT
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sof,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  output logic                      last_take,
  output logic [CRC_W-1:0]          crc_fin,
  output logic [8*ADDR_BYTES-1:0]   addr_fin
);
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [CNT_W-1:0]  cnt_q, base_cnt;
  logic [CRC_W-1:0]  crc_q, base_crc, crc_nx;
  logic [ADDR_W-1:0] addr_q, base_addr;
  logic              take;

  // a start pulse re-arms in the same cycle, so a byte beside it is byte 0
  always_comb begin
    base_cnt  = sof ? '0   : cnt_q;
    base_crc  = sof ? INIT : crc_q;
    base_addr = sof ? '0   : addr_q;
    take      = byte_valid && (base_cnt < CNT_W'(ADDR_BYTES));
    last_take = take && (base_cnt == CNT_W'(ADDR_BYTES - 1));
  end

  hf_crc_byte #(.CRC_W(CRC_W), .DATA_W(8), .POLY(POLY)) u_crc (
    .crc_in  (base_crc),
    .data_in (byte_data),
    .crc_out (crc_nx)
  );

  assign crc_fin  = crc_nx;
  assign addr_fin = {base_addr[ADDR_W-9:0], byte_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);   // disarmed until the first start pulse
      crc_q  <= INIT;
      addr_q <= '0;
    end else begin
      cnt_q  <= take ? base_cnt + 1'b1 : base_cnt;
      crc_q  <= take ? crc_nx   : base_crc;
      addr_q <= take ? addr_fin : base_addr;
    end
  end
endmodule

// File: rtl/hf_lookup.sv
module hf_lookup #(
  parameter int CRC_W = 32,
  parameter int IDX_W = 6,
  parameter int REG_W = 32,
  parameter int N_TBL = 2
) (
  input  logic [CRC_W-1:0]             crc,
  input  logic [N_TBL-1:0][REG_W-1:0]  tbl,
  output logic [IDX_W-1:0]             idx,
  output logic                         bit_set
);
  localparam int TBL_BITS = N_TBL * REG_W;

  logic [TBL_BITS-1:0] flat;

  // upper word occupies the upper index range
  assign flat    = tbl;
  assign idx     = crc[CRC_W-1 -: IDX_W];
  assign bit_set = flat[idx];
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 32,
  parameter int IDX_W      = 6,
  parameter int CRC_W      = 32,
  parameter int TAG_W      = 16,
  localparam int N_TBL     = (1 << IDX_W) / REG_W,
  localparam int SEL_W     = $clog2(hf_pkg::HF_SEL_TBL_BASE + N_TBL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_wr_sel,
  input  logic [REG_W-1:0]  cfg_wr_data,
  input  logic [SEL_W-1:0]  cfg_rd_sel,
  output logic [REG_W-1:0]  cfg_rd_data,
  input  logic              rx_sof,
  input  logic              rx_byte_valid,
  input  logic [7:0]        rx_byte,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_exact,
  output logic              res_hash,
  output logic [IDX_W-1:0]  res_index
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic [REG_W-1:0]            stn_hi;
  logic [REG_W-TAG_W-1:0]      stn_lo;
  logic [N_TBL-1:0][REG_W-1:0] tbl;
  logic                        last_take;
  logic [CRC_W-1:0]            crc_fin;
  logic [ADDR_W-1:0]           addr_fin;
  logic [IDX_W-1:0]            idx_c;
  logic                        hash_c, exact_c;

  hf_regs #(.REG_W(REG_W), .N_TBL(N_TBL), .SEL_W(SEL_W), .TAG_W(TAG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (cfg_rd_data),
    .stn_hi  (stn_hi),
    .stn_lo  (stn_lo),
    .tbl     (tbl)
  );

  hf_seq #(.ADDR_BYTES(ADDR_BYTES), .CRC_W(CRC_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .sof        (rx_sof),
    .byte_valid (rx_byte_valid),
    .byte_data  (rx_byte),
    .last_take  (last_take),
    .crc_fin    (crc_fin),
    .addr_fin   (addr_fin)
  );

  hf_lookup #(.CRC_W(CRC_W), .IDX_W(IDX_W), .REG_W(REG_W), .N_TBL(N_TBL)) u_lookup (
    .crc     (crc_fin),
    .tbl     (tbl),
    .idx     (idx_c),
    .bit_set (hash_c)
  );

  assign exact_c = (addr_fin == ADDR_W'({stn_hi, stn_lo}));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_exact <= 1'b0;
      res_hash  <= 1'b0;
      res_index <= '0;
    end else begin
      res_valid <= last_take;
      if (last_take) begin
        res_hit   <= exact_c | hash_c;
        res_exact <= exact_c;
        res_hash  <= hash_c;
        res_index <= idx_c;
      end
    end
  end
endmodule

// File: rtl/addr_hash_filter_chk.sv
module addr_hash_filter_chk #(
  parameter int ADDR_BYTES = 6,
  parameter int REG_W      = 32,
  parameter int SEL_W      = 2,
  parameter int TAG_W      = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_sof,
  input logic             rx_byte_valid,
  input logic [SEL_W-1:0] cfg_rd_sel,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_exact,
  input logic             res_hash
);
  localparam int CW = $clog2(ADDR_BYTES + 1);

  logic [CW-1:0] seen_q, seen_b;
  logic          sixth_q, sixth_c;

  always_comb begin
    seen_b  = rx_sof ? '0 : seen_q;
    sixth_c = rx_byte_valid && (seen_b == CW'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= CW'(ADDR_BYTES);
      sixth_q <= 1'b0;
    end else begin
      if (rx_byte_valid && seen_b < CW'(ADDR_BYTES)) seen_q <= seen_b + 1'b1;
      else                                            seen_q <= seen_b;
      sixth_q <= sixth_c;
    end
  end

  AST_STROBE_TIMING: assert property (@(posedge clk) disable iff (rst)
    res_valid == sixth_q);                                              // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);                                          // R8
  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable({res_hit, res_exact, res_hash}) |-> res_valid);            // R8
  AST_HIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_exact || res_hash));                               // R7
  AST_TAG_FIXED: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cfg_rd_sel) == SEL_W'(hf_pkg::HF_SEL_STN_LO))
      |-> cfg_rd_data[TAG_W-1:0] == hf_pkg::HF_TYPE_TAG);               // R6
endmodule

bind addr_hash_filter addr_hash_filter_chk #(
  .ADDR_BYTES(ADDR_BYTES), .REG_W(REG_W), .SEL_W(SEL_W), .TAG_W(TAG_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rx_sof        (rx_sof),
  .rx_byte_valid (rx_byte_valid),
  .cfg_rd_sel    (cfg_rd_sel),
  .cfg_rd_data   (cfg_rd_data),
  .res_valid     (res_valid),
  .res_hit       (res_hit),
  .res_exact     (res_exact),
  .res_hash      (res_hash)
);

// File: tb/addr_hash_filter_tb.sv
module addr_hash_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [1:0]  cfg_rd_sel = '0;
  logic [31:0] cfg_rd_data;
  logic        rx_sof = 1'b0;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        res_valid, res_hit, res_exact, res_hash;
  logic [5:0]  res_index;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_up, m_dn;   // bench copy of the table
  logic [47:0] m_stn;        // bench copy of the station address

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_hash_filter u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_sel(cfg_rd_sel), .cfg_rd_data(cfg_rd_data),
    .rx_sof(rx_sof), .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .res_valid(res_valid), .res_hit(res_hit), .res_exact(res_exact),
    .res_hash(res_hash), .res_index(res_index)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] mac);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = mac[47 - 8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB88320;
        else             c = c >> 1;
      end
    end
    return c;
  endfunction

  function automatic logic [5:0] ref_idx(input logic [47:0] mac);
    logic [31:0] c = ref_crc(mac);
    return c[31:26];
  endfunction

  function automatic logic ref_hash(input logic [47:0] mac);
    logic [5:0] ix = ref_idx(mac);
    return (ix >= 6'd32) ? m_up[ix - 6'd32] : m_dn[ix[4:0]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_sel = s; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    case (s)
      2'd0: m_stn[47:16] = d;
      2'd1: m_stn[15:0]  = d[31:16];
      2'd2: m_up = d;
      default: m_dn = d;
    endcase
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_rd_sel = s;
    @(negedge clk);
    chk(req, cfg_rd_data, exp);
  endtask

  task automatic put_byte(input logic [7:0] d, input logic sof_bit);
    @(negedge clk);
    rx_sof = sof_bit; rx_byte_valid = 1'b1; rx_byte = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_sof = 1'b0; rx_byte_valid = 1'b0;
    end
  endtask

  // send an address; sof_first puts the start pulse beside byte 0
  task automatic frame(input logic [47:0] mac, input bit sof_first, input int gap);
    logic e_exact, e_hash;
    logic [5:0] e_idx;
    e_exact = (mac == m_stn);
    e_hash  = ref_hash(mac);
    e_idx   = ref_idx(mac);
    if (!sof_first) begin
      @(negedge clk);
      rx_sof = 1'b1; rx_byte_valid = 1'b0;
    end
    for (int b = 0; b < 6; b++) begin
      put_byte(mac[47 - 8*b -: 8], sof_first && b == 0);
      if (b < 5 && gap > 0) idle(gap);
    end
    idle(1);
    chk("R8 strobe after sixth byte", 32'(res_valid), 32'd1);
    chk("R2 R3 index", 32'(res_index), 32'(e_idx));
    chk("R4 hash bit", 32'(res_hash), 32'(e_hash));
    chk("R5 exact compare", 32'(res_exact), 32'(e_exact));
    chk("R7 combined hit", 32'(res_hit), 32'(e_exact | e_hash));
    idle(1);
    chk("R8 single-cycle strobe", 32'(res_valid), 32'd0);
    chk("R8 verdict held", 32'(res_hit), 32'(e_exact | e_hash));
  endtask

  function automatic logic [47:0] rnd_mac();
    return {16'($urandom), $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] a, b;
    logic [5:0]  ia;
    void'($urandom(32'd20240611));
    m_up = '0; m_dn = '0; m_stn = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 strobe", 32'(res_valid), 32'd0);
    chk("R1 hit", 32'(res_hit), 32'd0);
    chk("R1 index", 32'(res_index), 32'd0);
    rd(2'd0, 32'h0, "R1 station hi");
    rd(2'd1, 32'h00008808, "R1 R6 station lo");
    rd(2'd2, 32'h0, "R1 table upper");
    rd(2'd3, 32'h0, "R1 table lower");

    // R9 bytes before any start pulse are ignored
    for (int k = 0; k < 6; k++) begin
      put_byte(8'(k + 1), 1'b0);
      @(negedge clk);
      chk("R9 unarmed bytes ignored", 32'(res_valid), 32'd0);
    end
    idle(2);
    chk("R9 unarmed no strobe", 32'(res_valid), 32'd0);

    // R10 / R6 register port
    wr(2'd0, 32'hA1B2C3D4);
    rd(2'd0, 32'hA1B2C3D4, "R10 station hi readback");
    wr(2'd1, 32'hE5F61234);
    rd(2'd1, 32'hE5F68808, "R6 tag bits fixed");
    wr(2'd2, 32'h5A5A0F0F);
    rd(2'd2, 32'h5A5A0F0F, "R10 table upper readback");
    wr(2'd3, 32'h3C3C9999);
    rd(2'd3, 32'h3C3C9999, "R10 table lower readback");

    // R5 exact match only: table cleared
    wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    a = 48'h02_11_22_33_44_55;
    wr(2'd0, a[47:16]); wr(2'd1, {a[15:0], 16'h0});
    frame(a, 1'b1, 0);
    frame(a ^ 48'h1, 1'b0, 1);         // last byte differs
    frame(a ^ 48'h01_00_00_00_00_00, 1'b1, 0);  // first byte differs

    // R4 both table halves: find addresses in each index range
    wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    a = rnd_mac();
    for (int k = 0; k < 200 && ref_idx(a) < 6'd32; k++) a = rnd_mac();
    b = rnd_mac();
    for (int k = 0; k < 200 && ref_idx(b) >= 6'd32; k++) b = rnd_mac();
    ia = ref_idx(a);
    wr(2'd2, 32'h1 << (ia - 6'd32));
    frame(a, 1'b1, 0);                 // upper half hit
    frame(b, 1'b1, 0);                 // lower half miss
    ia = ref_idx(b);
    wr(2'd3, 32'h1 << ia[4:0]);
    wr(2'd2, 32'h0);
    frame(b, 1'b0, 0);                 // lower half hit
    frame(a, 1'b0, 2);                 // upper now clear

    // R9 restart mid-address and extra bytes ignored
    put_byte(8'hFF, 1'b1); put_byte(8'hEE, 1'b0); put_byte(8'hDD, 1'b0);
    frame(b, 1'b1, 0);
    put_byte(8'h12, 1'b0); put_byte(8'h34, 1'b0);
    idle(1);
    chk("R9 extra bytes no strobe", 32'(res_valid), 32'd0);
    idle(1);
    chk("R9 extra bytes no strobe", 32'(res_valid), 32'd0);
    chk("R9 verdict unchanged", 32'(res_hit), 32'(ref_hash(b)));

    // random mix
    wr(2'd2, $urandom); wr(2'd3, $urandom);
    a = rnd_mac();
    wr(2'd0, a[47:16]); wr(2'd1, {a[15:0], 16'($urandom)});
    for (int k = 0; k < 40; k++) begin
      b = ($urandom_range(0, 3) == 0) ? m_stn : rnd_mac();
      frame(b, 1'($urandom_range(0, 1)), $urandom_range(0, 2));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule